// File: doc/BRIEF.md
# Masked Burst Address Counter with Address-Bus Readback

This block sits on one port of a synchronous multi-port memory and produces the burst address for that port. A counter can be loaded from the address inputs and then advanced one step per clock. A mask register, also loaded from the address inputs, decides which counter bits take part in the count. Bits whose mask bit is zero keep the value they were loaded with, and the carry skips over them. This gives wrapping bursts of any power-of-two length, placed anywhere in the address space.

Two active-low strobes let the host read the counter or the mask back over the port's own address pins. The address bus is modelled as a separate input, output and output enable. A small readback state machine owns that bus. It inserts one idle cycle before it drives the bus. While a readback is requested or in progress, it also holds the data-bus output enable off, whatever the chip enable says. A one-cycle active-low flag reports each time the masked counter field rolls over to zero.

The state machine has five states:
- `RB_IDLE`: the address bus is not driven.
- `RB_CNT_GAP` and `RB_MSK_GAP`: the one idle cycle after a readback source is accepted.
- `RB_CNT_DRIVE` and `RB_MSK_DRIVE`: the counter or the mask is on the address bus.

Its transitions are:
- *accept*: IDLE, or a state of the other source, goes to the GAP state of the source now selected.
- *settle*: GAP goes to DRIVE when the same source is still selected.
- *hold*: DRIVE stays in DRIVE while its source stays selected.
- *drop*: any state goes to IDLE when no readback is honoured.

Top module: `masked_burst_ctr`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the counter, sets every mask bit to one, drives `wrap_n` high and leaves the state machine in RB_IDLE with `addr_oe` low.
- R2: With `ld_n` low at an edge, the counter takes `addr_in`. Load wins over increment when both are low.
- R3: With `mload_n` low at an edge, the mask register takes `addr_in`, independently of the counter controls.
- R4: With `inc_n` low and `ld_n` high at an edge, the counter field made of the mask-one bits (bit i belongs to the field when mask bit i is 1) increases by one, with the carry passing only between field bits. Bits with mask 0 keep their value.
- R5: `wrap_n` is low for exactly the one cycle after an increment edge at which every field bit was one, so that the field rolls to zero. An empty mask counts as a roll-over on every increment. Otherwise `wrap_n` is high.
- R6: A counter readback (`crd_n` low) is honoured only while `ld_n` and `inc_n` are both high. Otherwise the request is ignored and the address bus stays undriven.
- R7: A mask readback (`mrd_n` low) is honoured only while `ld_n`, `inc_n`, `crd_n` and `mload_n` are all high.
- R8: When both strobes are low and the counter readback is honoured, the counter value is returned, not the mask.
- R9: A readback honoured at edge k gives a no-operation cycle with `addr_oe` low after edge k. After edge k+1, `addr_oe` is high and `addr_out` carries the selected value. The value is held while the request stays honoured, and `addr_oe` falls after the first edge at which no readback is honoured.
- R10: `data_oe` is high only when `ce_n` is low, `we_n` is high, no readback is requested and honoured, and the state machine is in RB_IDLE. Readback itself does not depend on `ce_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Combined port chip enable, active low |
| we_n | input | 1 | Write enable, active low; high means a read cycle |
| ld_n | input | 1 | Counter load from `addr_in`, active low |
| inc_n | input | 1 | Masked counter increment, active low |
| mload_n | input | 1 | Mask register load from `addr_in`, active low |
| crd_n | input | 1 | Counter readback strobe, active low |
| mrd_n | input | 1 | Mask readback strobe, active low |
| addr_in | input | AW | Address bus, input side |
| addr_out | output | AW | Address bus, output side, valid while `addr_oe` is high |
| addr_oe | output | 1 | Address bus output enable |
| data_oe | output | 1 | Data bus output enable for read data |
| wrap_n | output | 1 | Counter roll-over flag, low for one cycle |

## Verification
The counter and the mask are seen at the ports only through readback. A wrong increment or a wrong mask bit therefore appears as a wrong `addr_out` value two edges after the strobe is accepted. A wrong carry also shows one cycle earlier, as a `wrap_n` pulse that is missing or extra right after the increment. A state machine fault shows in the cycle it happens: `addr_oe` rises one edge too early or too late, or `data_oe` stays on during a readback. The bench sweeps every mask against every start value on a 4-bit counter and reads the result back after each step, so no counter fault can hide for more than a few cycles.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    // Readback source chosen by the arbiter for the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CNT  = 2'd1,
        SRC_MSK  = 2'd2
    } rb_src_t;

    // Readback state machine encoding.
    typedef enum logic [2:0] {
        RB_IDLE      = 3'd0,
        RB_CNT_GAP   = 3'd1,
        RB_CNT_DRIVE = 3'd2,
        RB_MSK_GAP   = 3'd3,
        RB_MSK_DRIVE = 3'd4
    } rb_state_t;

endpackage

// File: rtl/mbc_counter.sv
module mbc_counter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          inc_n,
    input  logic          mload_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cnt_q,
    output logic [AW-1:0] mask_q,
    output logic          wrap_n
);

    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

    logic [AW-1:0] filled;
    logic [AW-1:0] summed;
    logic [AW-1:0] cnt_step;
    logic          field_full;

    // Unmasked bits are forced to one so the carry ripples straight through them.
    always_comb begin
        filled     = cnt_q | ~mask_q;
        summed     = filled + {{(AW-1){1'b0}}, 1'b1};
        cnt_step   = (cnt_q & ~mask_q) | (summed & mask_q);
        field_full = &filled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!ld_n) begin
            cnt_q <= addr_in;
        end else if (!inc_n) begin
            cnt_q <= cnt_step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= ALL_ONES;
        end else if (!mload_n) begin
            mask_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_n <= 1'b1;
        end else begin
            wrap_n <= !(ld_n && !inc_n && field_full);
        end
    end

endmodule

// File: rtl/mbc_arbiter.sv
module mbc_arbiter
    import mbc_pkg::*;
(
    input  logic    ld_n,
    input  logic    inc_n,
    input  logic    mload_n,
    input  logic    crd_n,
    input  logic    mrd_n,
    output rb_src_t src
);

    logic cnt_ok;
    logic msk_ok;

    always_comb begin
        cnt_ok = !crd_n && ld_n && inc_n;
        msk_ok = !mrd_n && ld_n && inc_n && crd_n && mload_n;
        if (cnt_ok) begin
            src = SRC_CNT;
        end else if (msk_ok) begin
            src = SRC_MSK;
        end else begin
            src = SRC_NONE;
        end
    end

endmodule

// File: rtl/mbc_rb_fsm.sv
module mbc_rb_fsm
    import mbc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rb_src_t       src,
    input  logic [AW-1:0] cnt_q,
    input  logic [AW-1:0] mask_q,
    output logic [AW-1:0] addr_out,
    output logic          addr_oe,
    output logic          rb_busy
);

    rb_state_t state;
    rb_state_t state_nxt;
    rb_state_t accept;

    // accept: the gap state that belongs to the newly selected source
    always_comb begin
        unique case (src)
            SRC_CNT: accept = RB_CNT_GAP;
            SRC_MSK: accept = RB_MSK_GAP;
            default: accept = RB_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            RB_IDLE:      state_nxt = accept;
            RB_CNT_GAP:   state_nxt = (src == SRC_CNT) ? RB_CNT_DRIVE : accept;
            RB_CNT_DRIVE: state_nxt = (src == SRC_CNT) ? RB_CNT_DRIVE : accept;
            RB_MSK_GAP:   state_nxt = (src == SRC_MSK) ? RB_MSK_DRIVE : accept;
            RB_MSK_DRIVE: state_nxt = (src == SRC_MSK) ? RB_MSK_DRIVE : accept;
            default:      state_nxt = RB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RB_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        addr_out = '0;
        addr_oe  = 1'b0;
        rb_busy  = 1'b1;
        unique case (state)
            RB_IDLE: begin
                rb_busy = 1'b0;
            end
            RB_CNT_GAP, RB_MSK_GAP: begin
                addr_oe = 1'b0;
            end
            RB_CNT_DRIVE: begin
                addr_out = cnt_q;
                addr_oe  = 1'b1;
            end
            RB_MSK_DRIVE: begin
                addr_out = mask_q;
                addr_oe  = 1'b1;
            end
            default: begin
                rb_busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/masked_burst_ctr.sv
module masked_burst_ctr
    import mbc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          ld_n,
    input  logic          inc_n,
    input  logic          mload_n,
    input  logic          crd_n,
    input  logic          mrd_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic          addr_oe,
    output logic          data_oe,
    output logic          wrap_n
);

    logic [AW-1:0] cnt_q;
    logic [AW-1:0] mask_q;
    rb_src_t       src;
    logic          rb_busy;

    mbc_counter #(.AW(AW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_n    (ld_n),
        .inc_n   (inc_n),
        .mload_n (mload_n),
        .addr_in (addr_in),
        .cnt_q   (cnt_q),
        .mask_q  (mask_q),
        .wrap_n  (wrap_n)
    );

    mbc_arbiter u_arbiter (
        .ld_n    (ld_n),
        .inc_n   (inc_n),
        .mload_n (mload_n),
        .crd_n   (crd_n),
        .mrd_n   (mrd_n),
        .src     (src)
    );

    mbc_rb_fsm #(.AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .cnt_q    (cnt_q),
        .mask_q   (mask_q),
        .addr_out (addr_out),
        .addr_oe  (addr_oe),
        .rb_busy  (rb_busy)
    );

    // Read data may only leave the port when no readback owns the pins.
    always_comb begin
        data_oe = !ce_n && we_n && !rb_busy && (src == SRC_NONE);
    end

endmodule

// File: rtl/masked_burst_ctr_chk.sv
module masked_burst_ctr_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_n,
    input logic          inc_n,
    input logic          mload_n,
    input logic          crd_n,
    input logic          mrd_n,
    input logic [AW-1:0] addr_out,
    input logic          addr_oe,
    input logic          data_oe,
    input logic          wrap_n
);

    logic req_ok;
    assign req_ok = (!crd_n && ld_n && inc_n) ||
                    (!mrd_n && ld_n && inc_n && crd_n && mload_n);

    // R10
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> !data_oe);

    // R10
    data_off_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |-> !data_oe);

    // R9
    rb_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> ($past(req_ok, 1) && $past(req_ok, 2)));

    // R9
    rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && $past(addr_oe)) |-> $stable(addr_out));

    // R6
    rb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ok |=> !addr_oe);

    // R5
    wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrap_n) |-> $past(!inc_n && ld_n));

endmodule

bind masked_burst_ctr masked_burst_ctr_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .inc_n    (inc_n),
    .mload_n  (mload_n),
    .crd_n    (crd_n),
    .mrd_n    (mrd_n),
    .addr_out (addr_out),
    .addr_oe  (addr_oe),
    .data_oe  (data_oe),
    .wrap_n   (wrap_n)
);

// File: tb/sim_masked_burst_ctr.sv
`timescale 1ns/1ps
module sim_masked_burst_ctr;

    localparam int AW = 4;
    localparam int NV = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, we_n, ld_n, inc_n, mload_n, crd_n, mrd_n;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          addr_oe, data_oe, wrap_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    masked_burst_ctr #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .ld_n(ld_n), .inc_n(inc_n), .mload_n(mload_n),
        .crd_n(crd_n), .mrd_n(mrd_n), .addr_in(addr_in),
        .addr_out(addr_out), .addr_oe(addr_oe), .data_oe(data_oe),
        .wrap_n(wrap_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_ctrl();
        ld_n = 1'b1; inc_n = 1'b1; mload_n = 1'b1;
        crd_n = 1'b1; mrd_n = 1'b1;
    endtask

    // Bench model of the masked increment: ripple carry through mask-one bits only.
    function automatic int step_val(input int c, input int m, output bit wrapped);
        int r = c;
        bit carry = 1'b1;
        for (int i = 0; i < AW; i++) begin
            if (m[i]) begin
                r[i]  = c[i] ^ carry;
                carry = c[i] & carry;
            end
        end
        wrapped = carry;
        return r;
    endfunction

    // Full readback: gap cycle, drive cycle, release.
    task automatic readback(input bit use_mask, input int exp, input string req);
        if (use_mask) mrd_n = 1'b0; else crd_n = 1'b0;
        tick();
        check({req, " R9 gap"}, int'(addr_oe), 0);
        tick();
        check({req, " R9 drive"}, int'(addr_oe), 1);
        check(req, int'(addr_out), exp);
        crd_n = 1'b1; mrd_n = 1'b1;
        tick();
        check({req, " R9 release"}, int'(addr_oe), 0);
    endtask

    initial begin
        ce_n = 1'b1; we_n = 1'b1; addr_in = '0;
        idle_ctrl();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;

        // R1 reset state
        check("R1 wrap_n", int'(wrap_n), 1);
        check("R1 addr_oe", int'(addr_oe), 0);
        readback(1'b0, 0, "R1 counter");
        readback(1'b1, NV - 1, "R1 mask");

        // R2 load beats increment
        addr_in = 4'd5; ld_n = 1'b0; inc_n = 1'b0;
        tick();
        idle_ctrl();
        readback(1'b0, 5, "R2 load priority");

        // R3 mask sweep, R4 R5 exhaustive increment sweep
        for (int m = 0; m < NV; m++) begin
            for (int s = 0; s < NV; s++) begin
                bit w;
                int e;
                addr_in = AW'(m); mload_n = 1'b0; tick(); mload_n = 1'b1;
                addr_in = AW'(s); ld_n = 1'b0;    tick(); ld_n = 1'b1;
                if (s == 0) readback(1'b1, m, "R3 mask load");
                e = step_val(s, m, w);
                inc_n = 1'b0; tick(); inc_n = 1'b1;
                check("R5 wrap pulse", int'(wrap_n), w ? 0 : 1);
                crd_n = 1'b0; tick();
                check("R5 wrap one cycle", int'(wrap_n), 1);
                check("R9 gap", int'(addr_oe), 0);
                tick();
                check("R9 drive", int'(addr_oe), 1);
                check("R4 masked increment", int'(addr_out), e);
                crd_n = 1'b1; tick();
                check("R9 release", int'(addr_oe), 0);
            end
        end

        // R6 counter readback ignored while incrementing
        addr_in = 4'hF; mload_n = 1'b0; tick(); mload_n = 1'b1;
        addr_in = 4'd3; ld_n = 1'b0; tick(); ld_n = 1'b1;
        crd_n = 1'b0; inc_n = 1'b0; tick();
        check("R6 ignored gap", int'(addr_oe), 0);
        tick();
        check("R6 ignored drive", int'(addr_oe), 0);
        idle_ctrl();
        readback(1'b0, 5, "R6 counter advanced twice");

        // R7 mask readback ignored while mask loads
        addr_in = 4'd9; mrd_n = 1'b0; mload_n = 1'b0; tick();
        check("R7 ignored gap", int'(addr_oe), 0);
        tick();
        check("R7 ignored drive", int'(addr_oe), 0);
        idle_ctrl();
        readback(1'b1, 9, "R7 mask");

        // R8 both strobes: counter wins (counter 5, mask 9)
        crd_n = 1'b0; mrd_n = 1'b0; tick(); tick();
        check("R8 priority oe", int'(addr_oe), 1);
        check("R8 priority value", int'(addr_out), 5);
        idle_ctrl(); tick();

        // R10 data enable
        ce_n = 1'b0; we_n = 1'b1; #1;
        check("R10 idle read", int'(data_oe), 1);
        we_n = 1'b0; #1;
        check("R10 write", int'(data_oe), 0);
        we_n = 1'b1; crd_n = 1'b0; #1;
        check("R10 request", int'(data_oe), 0);
        tick();
        check("R10 gap", int'(data_oe), 0);
        tick();
        check("R10 drive", int'(data_oe), 0);
        check("R10 readback with ce active", int'(addr_out), 5);
        crd_n = 1'b1; #1;
        check("R10 busy after release", int'(data_oe), 0);
        tick();
        check("R10 idle again", int'(data_oe), 1);
        ce_n = 1'b1; #1;
        check("R10 deselected", int'(data_oe), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule